// File: doc/BRIEF.md
# Lockable Boot-Loaded Configuration Register

This block is one 32-bit system configuration word on a simple register bus. Writes take effect in a single clock cycle. Reads are combinational. After reset the word can take a single preload from a flash configuration word during the pre-boot window. The preload happens only when the flash controller reports the word as trusted. Some fields are never preloaded: the lock field, the four write-protect flags and the debug-port enable.

A two-bit lock field decides which bus writes are accepted. In the soft-locked state the configuration is frozen, but the lock field can still be rewritten. In the hard-locked state everything is frozen until the next system reset. Four write-protect flags are set-only. Software can set them, and only reset clears them. Each flag drives a dedicated inhibit output that downstream register banks use to block their own writes. The register also drives decoded configuration signals: the flash ECC mode, the RAM ECC disable, the debug-port enable and a gated trace-output enable.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset, reading offset 0x00 returns 0x7100000B. All four inhibit outputs are 0, lock_state is 00, dbg_port_en is 1 and flash_ecc_off is 1.
- R2: While lock_state is 00, a write to offset 0x00 stores bits 29:16 and 9:0 from the write data. Bit 31 always reads as 0.
- R3: While lock_state is 10, writes leave bits 31:16 and 13:0 unchanged. The lock field (bits 15:14) can still be rewritten to 00 or 11.
- R4: While lock_state is 11, no bus write changes any bit, including the lock field, until reset.
- R5: A write that carries 01 in bits 15:14 leaves the lock field unchanged. The other fields are still updated as the current lock state allows.
- R6: Bits 13,12,11,10 are set-only. A 1 in the write data sets the bit while lock_state is 00, and a 0 has no effect. Only reset clears them. They drive io_lock, pmd_lock, grp_lock and pmu_lock respectively.
- R7: On a boot_strobe with boot_fail=0 and boot_blank=0, the register loads boot_word into every bit except 31, 15:10 and 3. Those bits keep their values.
- R8: On a boot_strobe with boot_fail=1 or boot_blank=1, the register keeps its reset value.
- R9: Only the first boot_strobe after a reset can preload. Later strobes change nothing.
- R10: A bus write in the same cycle as boot_strobe is ignored.
- R11: Bit 30 (the RAM ECC disable, output ram_ecc_off) cannot be changed by a bus write. Only a trusted preload can change it.
- R12: trace_out_en is bit 2 ANDed with trace_allow. It is 0 whenever trace_allow is 0.
- R13: Bits 29:28 encode the flash ECC mode. Code 11 or 10 gives flash_ecc_off=1. Code 01 gives flash_ecc_dyn=1. Code 00 gives both outputs 0.
- R14: A write to any offset other than 0x00 has no effect. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Register bus byte offset for reads and writes |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| boot_strobe | input | 1 | One-cycle pre-boot load strobe |
| boot_word | input | 32 | Flash configuration word |
| boot_fail | input | 1 | Boot-configuration fail status |
| boot_blank | input | 1 | Blank / info-valid indication (1 = untrusted) |
| trace_allow | input | 1 | External trace enable |
| cfg_word | output | 32 | Stored configuration word |
| lock_state | output | 2 | Current lock field |
| io_lock | output | 1 | Write inhibit, bit 13 |
| pmd_lock | output | 1 | Write inhibit, bit 12 |
| grp_lock | output | 1 | Write inhibit, bit 11 |
| pmu_lock | output | 1 | Write inhibit, bit 10 |
| ram_ecc_off | output | 1 | RAM ECC disable, bit 30 |
| flash_ecc_off | output | 1 | Flash ECC disabled |
| flash_ecc_dyn | output | 1 | Flash dynamic ECC enabled |
| dbg_port_en | output | 1 | Debug port enable, bit 3 |
| trace_out_en | output | 1 | Gated trace-output enable |

## Verification
A wrong lock state shows up at the ports as an accepted or rejected write. The read data reveals it one cycle after the write that should have been blocked. It also shows directly on lock_state. A lost sticky flag or a repeated preload changes the inhibit outputs or the read data in the cycle after the offending strobe or write. A preload mask error shows in the read value right after the first trusted strobe. The bench therefore reads the word back after every write and strobe, in each lock state.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [WORD_W-1:0] RESET_VAL = 32'h7100_000B;
  // Fields written directly by the bus while open: bits 29:16 and 9:0
  localparam logic [WORD_W-1:0] GEN_MASK  = 32'h3FFF_03FF;
  // Fields taken from flash: all but 31, 15:10 and 3
  localparam logic [WORD_W-1:0] LOAD_MASK = 32'h7FFF_03F7;

  localparam int unsigned LOCK_LSB   = 14;
  localparam int unsigned STICKY_LSB = 10;
  localparam int unsigned STICKY_N   = 4;
  localparam int unsigned RAMECC_BIT = 30;
  localparam int unsigned RSVD_BIT   = 31;
  localparam int unsigned FECC_LSB   = 28;
  localparam int unsigned DBG_BIT    = 3;
  localparam int unsigned TRACE_BIT  = 2;

  typedef enum logic [1:0] {
    LK_OPEN = 2'b00,
    LK_RSVD = 2'b01,
    LK_SOFT = 2'b10,
    LK_HARD = 2'b11
  } lock_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_preload_gate.sv
module cfg_preload_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_strobe,
  input  logic boot_fail,
  input  logic boot_blank,
  output logic load_now
);

  logic done_q;
  logic done_d;
  logic done_en;

  always_comb begin
    done_en  = boot_strobe & ~done_q;
    done_d   = 1'b1;
    load_now = boot_strobe & ~done_q & ~boot_fail & ~boot_blank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  // R9: once a strobe has been seen, no later load
  p_single_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !load_now);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

endmodule

// File: rtl/cfg_write_mask.sv
module cfg_write_mask
  import cfg_lock_pkg::*;
(
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] nxt
);

  logic [1:0]          cur_lock;
  logic [1:0]          req_lock;
  logic                gen_ok;
  logic                lock_ok;
  logic [WORD_W-1:0]   gen_val;
  logic [STICKY_N-1:0] sticky_nxt;

  always_comb begin
    cur_lock = cur[LOCK_LSB +: 2];
    req_lock = wdata[LOCK_LSB +: 2];
    gen_ok   = (cur_lock == LK_OPEN);
    lock_ok  = ((cur_lock == LK_OPEN) || (cur_lock == LK_SOFT)) &&
               (req_lock != LK_RSVD);
    gen_val  = gen_ok ? ((cur & ~GEN_MASK) | (wdata & GEN_MASK)) : cur;
  end

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_comb begin
      sticky_nxt[i] = cur[STICKY_LSB+i] | (gen_ok & wdata[STICKY_LSB+i]);
    end
  end

  always_comb begin
    nxt = gen_val;
    nxt[STICKY_LSB +: STICKY_N] = sticky_nxt;
    nxt[LOCK_LSB +: 2] = lock_ok ? req_lock : cur_lock;
  end

endmodule

// File: rtl/cfg_out_decode.sv
module cfg_out_decode
  import cfg_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] state,
  input  logic              trace_allow,
  output logic [1:0]        lock_state,
  output logic [STICKY_N-1:0] inhibit,
  output logic              ram_ecc_off,
  output logic              flash_ecc_off,
  output logic              flash_ecc_dyn,
  output logic              dbg_port_en,
  output logic              trace_out_en
);

  logic [1:0] fecc;

  always_comb begin
    fecc          = state[FECC_LSB +: 2];
    lock_state    = state[LOCK_LSB +: 2];
    inhibit       = state[STICKY_LSB +: STICKY_N];
    ram_ecc_off   = state[RAMECC_BIT];
    flash_ecc_off = fecc[1];
    flash_ecc_dyn = (fecc == 2'b01);
    dbg_port_en   = state[DBG_BIT];
    trace_out_en  = state[TRACE_BIT] & trace_allow;
  end

  // R12: trace output is held off when the external enable is low
  p_trace_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_allow |-> !trace_out_en);

  // R13: the two ECC indications are exclusive
  p_ecc_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_ecc_off && flash_ecc_dyn));

endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REG_OFFSET  = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              boot_strobe,
  input  logic [31:0]       boot_word,
  input  logic              boot_fail,
  input  logic              boot_blank,
  input  logic              trace_allow,
  output logic [31:0]       cfg_word,
  output logic [1:0]        lock_state,
  output logic              io_lock,
  output logic              pmd_lock,
  output logic              grp_lock,
  output logic              pmu_lock,
  output logic              ram_ecc_off,
  output logic              flash_ecc_off,
  output logic              flash_ecc_dyn,
  output logic              dbg_port_en,
  output logic              trace_out_en
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic                rst_s_n;
  logic                load_now;
  logic                addr_hit;
  logic                wr_hit;
  logic                state_en;
  logic [WORD_W-1:0]   state_q;
  logic [WORD_W-1:0]   state_d;
  logic [WORD_W-1:0]   bus_next;
  logic [STICKY_N-1:0] inhibit;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  cfg_preload_gate u_pre (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .boot_strobe (boot_strobe),
    .boot_fail   (boot_fail),
    .boot_blank  (boot_blank),
    .load_now    (load_now)
  );

  cfg_write_mask u_wm (
    .cur   (state_q),
    .wdata (bus_wdata),
    .nxt   (bus_next)
  );

  always_comb begin
    addr_hit = (bus_addr == OFFS);
    wr_hit   = bus_wr_en & addr_hit & ~boot_strobe;
    state_en = load_now | wr_hit;
    if (load_now) state_d = (boot_word & LOAD_MASK) | (state_q & ~LOAD_MASK);
    else          state_d = bus_next;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      state_q <= RESET_VAL;
    else if (state_en) state_q <= state_d;
  end

  assign bus_rdata = addr_hit ? state_q : '0;
  assign cfg_word  = state_q;

  cfg_out_decode u_dec (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .state         (state_q),
    .trace_allow   (trace_allow),
    .lock_state    (lock_state),
    .inhibit       (inhibit),
    .ram_ecc_off   (ram_ecc_off),
    .flash_ecc_off (flash_ecc_off),
    .flash_ecc_dyn (flash_ecc_dyn),
    .dbg_port_en   (dbg_port_en),
    .trace_out_en  (trace_out_en)
  );

  assign pmu_lock = inhibit[0];
  assign grp_lock = inhibit[1];
  assign pmd_lock = inhibit[2];
  assign io_lock  = inhibit[3];

  // R4: hard lock persists until reset
  p_hard_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q[LOCK_LSB +: 2] == LK_HARD) |=> (state_q[LOCK_LSB +: 2] == LK_HARD));

  // R3: soft or hard lock freezes the general fields when no load strobe
  p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((state_q[LOCK_LSB +: 2] != LK_OPEN) && !boot_strobe) |=>
      $stable(state_q & (GEN_MASK | 32'h0000_3C00)));

  // R5: the reserved lock code never becomes the stored state
  p_no_rsvd_lock_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    state_q[LOCK_LSB +: 2] != LK_RSVD);

  // R11: bit 30 moves only on a qualified preload
  p_ramecc_bus_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !load_now |=> $stable(state_q[RAMECC_BIT]));

  // R2: reserved top bit always zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !state_q[RSVD_BIT]);

  // R10: write in a strobe cycle leaves the word as the preload path sets it
  p_strobe_blocks_wr_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (boot_strobe && !load_now) |=> $stable(state_q));

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky_chk
    // R6: a set flag stays set
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
      state_q[STICKY_LSB+i] |=> state_q[STICKY_LSB+i]);
  end

endmodule

// File: tb/sim_cfg_lock_reg.sv
module sim_cfg_lock_reg;

  localparam logic [31:0] RST  = 32'h7100_000B;
  localparam logic [31:0] GEN  = 32'h3FFF_03FF;
  localparam logic [31:0] LOAD = 32'h7FFF_03F7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        boot_strobe;
  logic [31:0] boot_word;
  logic        boot_fail;
  logic        boot_blank;
  logic        trace_allow;
  logic [31:0] cfg_word;
  logic [1:0]  lock_state;
  logic        io_lock, pmd_lock, grp_lock, pmu_lock;
  logic        ram_ecc_off, flash_ecc_off, flash_ecc_dyn, dbg_port_en, trace_out_en;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  cfg_lock_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boot_strobe(boot_strobe),
    .boot_word(boot_word), .boot_fail(boot_fail), .boot_blank(boot_blank),
    .trace_allow(trace_allow), .cfg_word(cfg_word), .lock_state(lock_state),
    .io_lock(io_lock), .pmd_lock(pmd_lock), .grp_lock(grp_lock),
    .pmu_lock(pmu_lock), .ram_ecc_off(ram_ecc_off),
    .flash_ecc_off(flash_ecc_off), .flash_ecc_dyn(flash_ecc_dyn),
    .dbg_port_en(dbg_port_en), .trace_out_en(trace_out_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd0(output logic [31:0] v);
    bus_addr = 8'h00;
    #1;
    v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    boot_strobe = 1'b0; boot_word = '0; boot_fail = 1'b0; boot_blank = 1'b0;
    trace_allow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic strobe(input logic [31:0] w, input logic f, input logic b);
    boot_word = w; boot_fail = f; boot_blank = b; boot_strobe = 1'b1;
    @(negedge clk);
    boot_strobe = 1'b0; boot_fail = 1'b0; boot_blank = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd0(v);
    chk("R1 reset value", v, RST);
    chk("R1 inhibits/lock", {26'd0, lock_state, io_lock, pmd_lock, grp_lock, pmu_lock}, 32'd0);
    chk("R1 dbg/ecc", {30'd0, dbg_port_en, flash_ecc_off}, 32'd3);
  endtask

  task automatic t_open_write();
    logic [31:0] v;
    logic [31:0] w;
    do_reset();
    w = 32'hC5A5_0356;
    bus_write(8'h00, w);
    rd0(v);
    chk("R2 open write", v, (RST & ~GEN) | (w & GEN));
    bus_write(8'h00, 32'h0000_0000);
    rd0(v);
    chk("R11 bit30 kept on write", v, 32'h4000_0000);
    chk("R13 code00", {30'd0, flash_ecc_off, flash_ecc_dyn}, 32'd0);
    bus_write(8'h00, 32'h1000_0000);
    chk("R13 code01", {30'd0, flash_ecc_off, flash_ecc_dyn}, 32'd1);
    bus_write(8'h00, 32'h2000_0000);
    chk("R13 code10", {30'd0, flash_ecc_off, flash_ecc_dyn}, 32'd2);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    do_reset();
    bus_write(8'h00, 32'h7100_240B);
    rd0(v);
    chk("R6 set", v, 32'h7100_240B);
    chk("R6 outputs", {28'd0, io_lock, pmd_lock, grp_lock, pmu_lock}, 32'h9);
    bus_write(8'h00, 32'h7100_000B);
    rd0(v);
    chk("R6 zero no effect", v, 32'h7100_240B);
    do_reset();
    rd0(v);
    chk("R6 cleared by reset", v, RST);
  endtask

  task automatic t_soft_lock();
    logic [31:0] v;
    do_reset();
    bus_write(8'h00, 32'h7100_800B);
    rd0(v);
    chk("R3 enter soft", v, 32'h7100_800B);
    bus_write(8'h00, 32'h0000_BC00);
    rd0(v);
    chk("R3 soft blocks fields", v, 32'h7100_800B);
    bus_write(8'h00, 32'h7100_C00F);
    rd0(v);
    chk("R3 soft to hard", v, 32'h7100_C00B);
    do_reset();
    bus_write(8'h00, 32'h7100_800B);
    bus_write(8'h00, 32'h0000_0000);
    rd0(v);
    chk("R3 soft reopen", v, 32'h7100_000B);
  endtask

  task automatic t_hard_lock();
    logic [31:0] v;
    do_reset();
    bus_write(8'h00, 32'h7100_C00B);
    bus_write(8'h00, 32'h0000_0000);
    rd0(v);
    chk("R4 hard blocks clear", v, 32'h7100_C00B);
    bus_write(8'h00, 32'h0000_BC04);
    rd0(v);
    chk("R4 hard blocks soft", v, 32'h7100_C00B);
  endtask

  task automatic t_rsvd_lock();
    logic [31:0] v;
    do_reset();
    bus_write(8'h00, 32'h7100_400F);
    rd0(v);
    chk("R5 open rsvd code", v, 32'h7100_000F);
    bus_write(8'h00, 32'h7100_800B);
    bus_write(8'h00, 32'h7100_400B);
    chk("R5 soft rsvd code", {30'd0, lock_state}, 32'd2);
  endtask

  task automatic t_preload();
    logic [31:0] v;
    do_reset();
    strobe(32'hFFFF_FFFF, 1'b0, 1'b0);
    rd0(v);
    chk("R7 trusted load", v, (32'hFFFF_FFFF & LOAD) | (RST & ~LOAD));
    strobe(32'h0000_0000, 1'b0, 1'b0);
    rd0(v);
    chk("R9 second strobe", v, 32'h7FFF_03FF);
    do_reset();
    strobe(32'h0000_0000, 1'b0, 1'b0);
    rd0(v);
    chk("R11 load clears bit30", {31'd0, ram_ecc_off}, 32'd0);
    chk("R7 dbg kept", v, 32'h0000_0008);
    do_reset();
    strobe(32'h0000_0000, 1'b1, 1'b0);
    rd0(v);
    chk("R8 fail keeps reset", v, RST);
    do_reset();
    strobe(32'h0000_0000, 1'b0, 1'b1);
    rd0(v);
    chk("R8 blank keeps reset", v, RST);
    do_reset();
    bus_addr = 8'h00; bus_wdata = 32'h0000_0000; bus_wr_en = 1'b1;
    strobe(RST, 1'b0, 1'b0);
    bus_wr_en = 1'b0;
    rd0(v);
    chk("R10 write in strobe", v, RST);
  endtask

  task automatic t_trace();
    do_reset();
    bus_write(8'h00, 32'h7100_000F);
    trace_allow = 1'b0; #1;
    chk("R12 gated off", {31'd0, trace_out_en}, 32'd0);
    trace_allow = 1'b1; #1;
    chk("R12 passes", {31'd0, trace_out_en}, 32'd1);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    do_reset();
    bus_write(8'h04, 32'h0000_0000);
    rd0(v);
    chk("R14 other offset write", v, RST);
    bus_addr = 8'h04; #1;
    chk("R14 other offset read", bus_rdata, 32'd0);
    bus_addr = 8'h00;
  endtask

  initial begin
    t_reset();
    t_open_write();
    t_sticky();
    t_soft_lock();
    t_hard_lock();
    t_rsvd_lock();
    t_preload();
    t_trace();
    t_addr();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule